// File: doc/BRIEF.md
# APB Periodic Down-Counting Timer

A 32-bit timer reached through an APB slave port. Once started, the count steps down by one on each counting tick. A counting tick is either every bus clock, a bus clock on which an external line is high, or a rising edge of that external line. When the count goes from one to zero, a latched level interrupt can be raised. The count then stays at zero for one more tick and reloads from a programmable reload register.

Software sets the mode in a four-bit control word. It can set or read the count and the reload value directly, and it clears the interrupt by writing a one to the status word. A bank of read-only identification bytes sits at the top of the 4 KiB window. The external line passes through a two-flop synchroniser before it is used. In clock mode, a one-cycle pulse is formed on its synchronised rising edge.

Top module: `apb_dn_timer`

## Requirements
- R1: After a synchronous reset, the control, count, reload and status words all read 0, and `irq` is 0.
- R2: The control word (word address 0x000) keeps only bits [3:0], and the other bits read as 0. Bit 0 is run, bit 1 is gate-by-external-line, bit 2 is count-on-external-edge, and bit 3 is interrupt enable.
- R3: With run=1 and both external bits 0, the count (word 0x004) drops by one on every clock. With run=0 the count holds.
- R4: A tick that takes the count from 1 to 0 while interrupt enable is 1 sets status bit 0 (word 0x00C), and `irq` goes to 1 on that same clock edge. `irq` always shows the status bit.
- R5: A tick at a count of 0 loads the reload value (word 0x008). A period therefore lasts reload+1 ticks, and the count reads 0 for one tick after expiry.
- R6: With a reload value of 0, the count stays at 0 after an expiry, and no further interrupt follows.
- R7: Writing the reload word sets both the reload value and the count to the written data.
- R8: Writing the status word with bit 0 = 1 clears the status bit, and writing bit 0 = 0 leaves it alone. If an expiry falls on the same cycle as a clear, the expiry wins.
- R9: With interrupt enable = 0, an expiry leaves the status bit and `irq` at 0.
- R10: In gate mode (control bit 1), no tick occurs while the synchronised external line is low. The line reaches the counter two clocks late.
- R11: In external-edge mode (control bit 2), there is exactly one tick for each rising edge of the synchronised external line.
- R12: Word addresses 0xFD0 to 0xFFC read, in rising address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with zeros above bit 7. Writes to these words change nothing.
- R13: A bus write to the count takes priority over a tick on the same clock. Unmapped words read 0, writes to them change nothing, and `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address; bits [1:0] are ignored |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered in the setup phase |
| pready | output | 1 | Always 1, no wait states |
| ext_in | input | 1 | External gate or count-clock line (asynchronous) |
| irq | output | 1 | Latched level interrupt |

## Verification
The properties assume well-formed APB traffic: every access is a setup cycle followed by a single access cycle, and address and data stay stable across both. They also assume that a write to the count or reload word is the only thing that overrides a tick. The stimulus tasks produce only this two-phase shape at word-aligned addresses. They drive the external line at falling clock edges and hold each level for at least two clocks, so that every rising edge survives the synchroniser. Random traffic is limited to reload writes while the timer is stopped, identification reads and unmapped accesses, so the expected values follow directly from the requirements.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  // Word indices (byte address >> 2); decoders depend on these positions.
  localparam int unsigned WIX_CTRL   = 32'h000;
  localparam int unsigned WIX_COUNT  = 32'h001;
  localparam int unsigned WIX_RELOAD = 32'h002;
  localparam int unsigned WIX_STATUS = 32'h003;
  localparam int unsigned WIX_IDBASE = 32'h3F4;
  localparam int unsigned ID_WORDS   = 12;

  typedef struct packed {
    logic irq_en;    // bit 3
    logic ext_clk;   // bit 2
    logic ext_gate;  // bit 1
    logic run;       // bit 0
  } ctrl_t;

  function automatic logic [7:0] id_byte(input int unsigned idx);
    case (idx)
      0:       id_byte = 8'h04;
      4:       id_byte = 8'h22;
      5:       id_byte = 8'hB8;
      6:       id_byte = 8'h1B;
      8:       id_byte = 8'h0D;
      9:       id_byte = 8'hF0;
      10:      id_byte = 8'h05;
      11:      id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tmr_ext_sync.sv
`timescale 1ns/1ps
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_cnt_i,
  input  logic              wr_rld_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] rld_o,
  output logic              expire_o
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] rld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (wr_rld_i) begin
      rld_q <= wdata_i;
      cnt_q <= wdata_i;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= rld_q;
      else             cnt_q <= cnt_q - DATA_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign rld_o    = rld_q;
  assign expire_o = tick_i & (cnt_q == DATA_W'(1)) & ~wr_cnt_i & ~wr_rld_i;

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] rld_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              wr_cnt_o,
  output logic              wr_rld_o,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o
);

  localparam int WIX_W = ADDR_W - 2;

  logic [WIX_W-1:0]  widx;
  logic [31:0]       widx32;
  logic              wr_acc;
  logic              rd_setup;
  logic              wr_ctrl;
  logic              wr_stat;
  ctrl_t             ctrl_q;
  logic              stat_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] prdata_q;
  logic              unused_bits;

  assign widx     = paddr[ADDR_W-1:2];
  assign widx32   = 32'(widx);
  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign wr_ctrl  = wr_acc & (widx32 == WIX_CTRL);
  assign wr_cnt_o = wr_acc & (widx32 == WIX_COUNT);
  assign wr_rld_o = wr_acc & (widx32 == WIX_RELOAD);
  assign wr_stat  = wr_acc & (widx32 == WIX_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(pwdata[3:0]);
      if (expire_i && ctrl_q.irq_en) stat_q <= 1'b1;
      else if (wr_stat && pwdata[0]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (widx32 == WIX_CTRL)        rd_mux = DATA_W'(ctrl_q);
    else if (widx32 == WIX_COUNT)  rd_mux = cnt_i;
    else if (widx32 == WIX_RELOAD) rd_mux = rld_i;
    else if (widx32 == WIX_STATUS) rd_mux = DATA_W'(stat_q);
    else if (widx32 >= WIX_IDBASE && widx32 < WIX_IDBASE + ID_WORDS)
      rd_mux = DATA_W'(id_byte(widx32 - WIX_IDBASE));
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata_q <= '0;
    else if (rd_setup) prdata_q <= rd_mux;
  end

  assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:4]};
  assign ctrl_o      = ctrl_q;
  assign prdata_o    = prdata_q;
  assign irq_o       = stat_q;

endmodule

// File: rtl/apb_dn_timer.sv
`timescale 1ns/1ps
module apb_dn_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              ext_in,
  output logic              irq
);

  ctrl_t             ctrl_w;
  logic              ext_lvl;
  logic              ext_rise;
  logic              tick_w;
  logic              wr_cnt_w;
  logic              wr_rld_w;
  logic              expire_w;
  logic [DATA_W-1:0] cnt_w;
  logic [DATA_W-1:0] rld_w;

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .ext_i  (ext_in),
    .lvl_o  (ext_lvl),
    .rise_o (ext_rise)
  );

  // Gate and edge modes combine: each enabled qualifier must hold.
  assign tick_w = ctrl_w.run
                & (~ctrl_w.ext_gate | ext_lvl)
                & (~ctrl_w.ext_clk  | ext_rise);

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_w),
    .wr_cnt_i (wr_cnt_w),
    .wr_rld_i (wr_rld_w),
    .wdata_i  (pwdata),
    .cnt_o    (cnt_w),
    .rld_o    (rld_w),
    .expire_o (expire_w)
  );

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .cnt_i    (cnt_w),
    .rld_i    (rld_w),
    .expire_i (expire_w),
    .ctrl_o   (ctrl_w),
    .wr_cnt_o (wr_cnt_w),
    .wr_rld_o (wr_rld_w),
    .prdata_o (prdata),
    .irq_o    (irq)
  );

  assign pready = 1'b1;

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] rld,
  input logic              tick,
  input logic              irq_en
);

  logic acc, w_cnt, w_rld, w_stat;
  assign acc    = psel && penable && pwrite;
  assign w_cnt  = acc && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign w_rld  = acc && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign w_stat = acc && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(3));

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt > DATA_W'(1) && !w_cnt && !w_rld) |=> cnt == $past(cnt) - DATA_W'(1)); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!tick && !w_cnt && !w_rld) |=> $stable(cnt)); // R3
  AST_EXPIRE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == DATA_W'(1) && irq_en && !w_cnt && !w_rld) |=> irq); // R4
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0 && !w_cnt && !w_rld) |=> cnt == $past(rld)); // R5
  AST_RLD_LOADS: assert property (@(posedge clk) disable iff (rst)
    w_rld |=> (cnt == $past(pwdata) && rld == $past(pwdata))); // R7
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (w_stat && pwdata[0] && !(tick && cnt == DATA_W'(1))) |=> !irq); // R8
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (w_stat && !pwdata[0] && irq) |=> irq); // R8
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !irq) |=> !irq); // R9
  AST_VAL_PRIO: assert property (@(posedge clk) disable iff (rst)
    w_cnt |=> cnt == $past(pwdata)); // R13

endmodule

bind apb_dn_timer tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .irq     (irq),
  .cnt     (cnt_w),
  .rld     (rld_w),
  .tick    (tick_w),
  .irq_en  (ctrl_w.irq_en)
);

// File: tb/apb_dn_timer_bench.sv
`timescale 1ns/1ps
module apb_dn_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        ext_in = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  apb_dn_timer u_apb_dn_timer (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .ext_in(ext_in), .irq(irq)
  );

  localparam logic [11:0] A_CTRL = 12'h000, A_CNT = 12'h004,
                          A_RLD = 12'h008, A_STAT = 12'h00C;

  function automatic logic [31:0] exp_id(input int idx);
    logic [7:0] b;
    case (idx)
      0: b = 8'h04; 4: b = 8'h22; 5: b = 8'hB8; 6: b = 8'h1B;
      8: b = 8'h0D; 9: b = 8'hF0; 10: b = 8'h05; 11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return {24'h0, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at a falling edge.
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] last_rld;
    void'($urandom(32'd7781));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CTRL, rd); check("R1 ctrl", rd, 0);
    bus_rd(A_CNT, rd);  check("R1 count", rd, 0);
    bus_rd(A_RLD, rd);  check("R1 reload", rd, 0);
    bus_rd(A_STAT, rd); check("R1 status", rd, 0);
    check("R1 irq", {31'h0, irq}, 0);
    check("R13 pready", {31'h0, pready}, 1);

    // R2 control width
    bus_wr(A_CTRL, 32'hFFFF_FFF0); bus_rd(A_CTRL, rd); check("R2 upper", rd, 0);
    bus_wr(A_CTRL, 32'hFFFF_FFFF); bus_rd(A_CTRL, rd); check("R2 low4", rd, 32'hF);
    bus_wr(A_CTRL, 0);

    // R3 free-running decrement and stop
    bus_wr(A_CNT, 100);
    bus_wr(A_CTRL, 1);
    bus_rd(A_CNT, rd); check("R3 first", rd, 100);
    bus_rd(A_CNT, rd); check("R3 step", rd, 98);
    // R13 count write beats the tick on the same edge
    bus_wr(A_CNT, 7);
    bus_rd(A_CNT, rd); check("R13 priority", rd, 7);
    bus_wr(A_CTRL, 0);
    bus_rd(A_CNT, rd);
    idle(10);
    begin
      logic [31:0] rd2;
      bus_rd(A_CNT, rd2); check("R3 stopped", rd2, rd);
    end

    // R4/R5 expiry, hold at zero, reload
    bus_wr(A_RLD, 3);
    bus_wr(A_CTRL, 32'h9);
    check("R4 before", {31'h0, irq}, 0);
    idle(2); check("R4 at count1", {31'h0, irq}, 0);
    idle(1); check("R4 expiry", {31'h0, irq}, 1);
    bus_rd(A_CNT, rd); check("R5 hold zero", rd, 0);
    bus_rd(A_CNT, rd); check("R5 reloaded", rd, 2);
    bus_wr(A_CTRL, 0);
    bus_rd(A_CNT, rd); check("R5 after stop", rd, 2);
    bus_wr(A_STAT, 0); check("R8 write0 keeps", {31'h0, irq}, 1);
    bus_rd(A_STAT, rd); check("R8 status read", rd, 1);
    bus_wr(A_STAT, 1); check("R8 write1 clears", {31'h0, irq}, 0);

    // R6 reload of zero: one expiry then silence
    bus_wr(A_RLD, 0);
    bus_wr(A_CNT, 1);
    bus_wr(A_CTRL, 32'h9);
    idle(1); check("R6 single expiry", {31'h0, irq}, 1);
    bus_wr(A_STAT, 1);
    idle(20); check("R6 no repeat", {31'h0, irq}, 0);
    bus_rd(A_CNT, rd); check("R6 stays zero", rd, 0);

    // R9 interrupt disabled
    bus_wr(A_CTRL, 0);
    bus_wr(A_RLD, 2);
    bus_wr(A_CTRL, 1);
    idle(12);
    check("R9 irq", {31'h0, irq}, 0);
    bus_rd(A_STAT, rd); check("R9 status", rd, 0);
    bus_wr(A_CTRL, 0);

    // R10 gate mode
    bus_wr(A_CNT, 100);
    bus_wr(A_CTRL, 32'h3);
    idle(10);
    bus_rd(A_CNT, rd); check("R10 held low", rd, 100);
    ext_in = 1; idle(10); ext_in = 0; idle(6);
    bus_rd(A_CNT, rd); check("R10 gated ticks", rd, 90);
    bus_wr(A_CTRL, 0);

    // R11 external edge mode
    bus_wr(A_CNT, 50);
    bus_wr(A_CTRL, 32'h5);
    for (int p = 0; p < 8; p++) begin
      ext_in = 1; idle(2); ext_in = 0; idle(2);
    end
    idle(6);
    bus_rd(A_CNT, rd); check("R11 edge ticks", rd, 42);
    bus_wr(A_CTRL, 0);

    // R12 identification words, directed
    for (int i = 0; i < 12; i++) begin
      bus_rd(12'hFD0 + 12'(4 * i), rd); check("R12 id", rd, exp_id(i));
    end

    // Random mix: R7 reload load, R12 id reads/writes, R13 unmapped
    last_rld = 32'h1234_5678;
    bus_wr(A_RLD, last_rld);
    for (int k = 0; k < 40; k++) begin
      int kind;
      kind = $urandom_range(0, 2);
      if (kind == 0) begin
        last_rld = $urandom;
        bus_wr(A_RLD, last_rld);
        bus_rd(A_RLD, rd); check("R7 reload", rd, last_rld);
        bus_rd(A_CNT, rd); check("R7 count", rd, last_rld);
      end else if (kind == 1) begin
        int idx;
        idx = $urandom_range(0, 11);
        bus_wr(12'hFD0 + 12'(4 * idx), $urandom);
        bus_rd(12'hFD0 + 12'(4 * idx), rd); check("R12 id ro", rd, exp_id(idx));
      end else begin
        logic [11:0] a;
        a = {10'($urandom_range(4, 1011)), 2'b00};
        bus_wr(a, $urandom);
        bus_rd(a, rd); check("R13 unmapped", rd, 0);
        bus_rd(A_RLD, rd); check("R13 no side effect", rd, last_rld);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule